// File: doc/BRIEF.md
# Mode Register Command Decoder with Guarded Flash Entry

This block sits behind the serial register port of a system-basis controller. It takes each 16-bit command word along with a write strobe and decodes the words aimed at the mode register. From those words it keeps the controller's operating mode, the level of the enable pin, the software-development flag, and which status source the next read returns. The serial framing, the transceivers and the watchdog period timer are outside this block. The block only receives a qualifier that says whether the current write counts as a valid watchdog service. It also receives a 1 ms tick.

Flash mode cannot be reached with a single mode write. Software must issue four mode writes in a fixed order, each one a valid watchdog service: Normal, Flash, Normal, Flash. The fourth write raises a one-cycle system-reset request, drops the controller into start-up, and records a flash-sequence code in the reset-source field. After that, an initialize-Flash write moves the controller into Flash mode, but only while a short window counted in 1 ms ticks is still open. Any out-of-order write, read-only access or failed watchdog qualifier sends the sequence back to its start.

Top module: `sbc_mode_ctrl`

## Requirements
- R1: A write whose address bits [15:14] are not 00 changes none of the outputs.
- R2: Every write with address 00 loads `rd_diag` from bit 13, including read-only accesses: 1 selects the diagnosis register and 0 selects the status register.
- R3: A write with address 00 and bit 12 set leaves `op_mode`, `en_out` and `sw_dev` unchanged and returns the flash-entry sequence to its start.
- R4: The mode code sits in bits [5:3]. Outside Flash mode, 001 and 101 give Normal, 010 gives Standby and 100 gives Sleep. `op_mode` encodes start-up as 0, Normal 1, Standby 2, Sleep 3 and Flash 4, and the new value appears one clock after the write.
- R5: Every accepted mode write loads `sw_dev` from bit 2 and `en_out` from bit 1. A write is accepted when its address is 00, bit 12 is clear and the mode code is not 000.
- R6: A write with mode code 000 changes neither the mode nor `en_out` nor `sw_dev`, and it returns the sequence to its start.
- R7: Four accepted writes with `wd_ok` high and codes 001, 111, 001, 111 in that order give a one-cycle `sys_rst_req` pulse one clock after the fourth write. At the same time `op_mode` becomes 0 and `rst_src` becomes 4'b1010.
- R8: The sequence restarts from the beginning on any address-00 write that is not the expected next step: wrong code, `wd_ok` low, read-only, or code 000. A later 111 then causes no reset.
- R9: Code 011 enters Flash only from start-up, only when `rst_src` is 4'b1010, and only before `INIT_WIN_MS` ticks have passed since the sequence reset. Otherwise it changes no state.
- R10: In Flash mode only code 110 is obeyed, and it returns `op_mode` to start-up. Code 111 never changes `op_mode` directly.
- R11: After reset, `op_mode` is 0, `en_out`, `sw_dev`, `rd_diag` and `sys_rst_req` are 0, and `rst_src` is 4'b0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 16 | Command word from the serial port |
| cmd_wr | input | 1 | One-cycle strobe marking a new command word |
| wd_ok | input | 1 | The current write is a valid watchdog service |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| op_mode | output | 3 | Current operating mode |
| en_out | output | 1 | Enable pin level |
| sw_dev | output | 1 | Software-development mode flag |
| rd_diag | output | 1 | Read-back source select (1 = diagnosis) |
| sys_rst_req | output | 1 | One-cycle system reset request |
| rst_src | output | 4 | Source of the most recent reset |

## Verification
The bench attacks the flash-entry sequence from several sides. One test breaks the order with a Standby command. Another drops the watchdog qualifier on the third step. A third slips in a read-only access. A tracker that ignored any of these would issue a reset where none is due. The initialize-Flash window is probed one tick inside its limit and exactly at its limit, which catches an off-by-one counter. A design that accepted Flash directly, or obeyed Normal while in Flash, would show the wrong mode on the cycle after the write.

// File: rtl/sbc_mode_pkg.sv
package sbc_mode_pkg;

  typedef enum logic [2:0] {
    OP_STARTUP = 3'd0,
    OP_NORMAL  = 3'd1,
    OP_STANDBY = 3'd2,
    OP_SLEEP   = 3'd3,
    OP_FLASH   = 3'd4
  } op_state_e;

  localparam logic [2:0] MC_NONE        = 3'b000;
  localparam logic [2:0] MC_NORMAL      = 3'b001;
  localparam logic [2:0] MC_STANDBY     = 3'b010;
  localparam logic [2:0] MC_INIT_FLASH  = 3'b011;
  localparam logic [2:0] MC_SLEEP       = 3'b100;
  localparam logic [2:0] MC_INIT_NORMAL = 3'b101;
  localparam logic [2:0] MC_LEAVE_FLASH = 3'b110;
  localparam logic [2:0] MC_FLASH       = 3'b111;

  localparam logic [3:0] SRC_POWER = 4'b0001;
  localparam logic [3:0] SRC_FLASH = 4'b1010;

  typedef struct packed {
    logic       hit;
    logic       rd_diag;
    logic       ro;
    logic [2:0] mcode;
    logic       sw_dev;
    logic       en;
  } cmd_fields_t;

  // Mode code expected at a given step of the flash-entry sequence
  function automatic logic [2:0] seq_code(input logic [1:0] step);
    return step[0] ? MC_FLASH : MC_NORMAL;
  endfunction

  // Operating mode that follows an accepted mode write
  function automatic op_state_e next_op(input op_state_e cur,
                                        input logic [2:0] code,
                                        input logic flash_ok);
    op_state_e nxt;
    nxt = cur;
    if (cur == OP_FLASH) begin
      if (code == MC_LEAVE_FLASH) nxt = OP_STARTUP;
    end else begin
      case (code)
        MC_NORMAL, MC_INIT_NORMAL: nxt = OP_NORMAL;
        MC_STANDBY:                nxt = OP_STANDBY;
        MC_SLEEP:                  nxt = OP_SLEEP;
        MC_INIT_FLASH:             if (flash_ok) nxt = OP_FLASH;
        default:                   nxt = cur;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/sbc_cmd_decode.sv
module sbc_cmd_decode
  import sbc_mode_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              cmd_wr,
  output cmd_fields_t       fields,
  output logic              wr_ok
);
  localparam int ADDR_HI = WORD_W - 1;
  localparam int ADDR_LO = WORD_W - 2;

  always_comb begin
    fields.hit     = cmd_wr && (cmd_word[ADDR_HI:ADDR_LO] == 2'b00);
    fields.rd_diag = cmd_word[13];
    fields.ro      = cmd_word[12];
    fields.mcode   = cmd_word[5:3];
    fields.sw_dev  = cmd_word[2];
    fields.en      = cmd_word[1];
    wr_ok          = fields.hit && !fields.ro && (fields.mcode != MC_NONE);
  end
endmodule

// File: rtl/sbc_flash_seq.sv
module sbc_flash_seq
  import sbc_mode_pkg::*;
#(
  parameter int INIT_WIN_MS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_hit,
  input  logic       wr_ok,
  input  logic [2:0] mcode,
  input  logic       wd_ok,
  input  logic       tick_1ms,
  output logic       seq_fire,
  output logic       win_open
);
  localparam int CNT_W = $clog2(INIT_WIN_MS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_WIN_MS - 1);

  logic [1:0]       step;
  logic             step_match;
  logic [CNT_W-1:0] win_cnt;

  assign step_match = wr_ok && wd_ok && (mcode == seq_code(step));
  assign seq_fire   = step_match && (step == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
    end else if (reg_hit) begin
      step <= step_match ? step + 2'd1 : 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open <= 1'b0;
      win_cnt  <= '0;
    end else if (seq_fire) begin
      win_open <= 1'b1;
      win_cnt  <= '0;
    end else if (tick_1ms && win_open) begin
      if (win_cnt == CNT_LAST) win_open <= 1'b0;
      else                     win_cnt  <= win_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sbc_mode_regs.sv
module sbc_mode_regs
  import sbc_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  cmd_fields_t fields,
  input  logic        wr_ok,
  input  logic        seq_fire,
  input  logic        win_open,
  output op_state_e   op_q,
  output logic        en_q,
  output logic        sw_dev_q,
  output logic        rd_diag_q,
  output logic        rst_req_q,
  output logic [3:0]  rst_src_q
);
  logic flash_ok;
  assign flash_ok = (op_q == OP_STARTUP) && win_open && (rst_src_q == SRC_FLASH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_STARTUP;
      en_q      <= 1'b0;
      sw_dev_q  <= 1'b0;
      rd_diag_q <= 1'b0;
      rst_req_q <= 1'b0;
      rst_src_q <= SRC_POWER;
    end else begin
      rst_req_q <= 1'b0;
      if (fields.hit) rd_diag_q <= fields.rd_diag;
      if (wr_ok) begin
        en_q     <= fields.en;
        sw_dev_q <= fields.sw_dev;
      end
      if (seq_fire) begin
        op_q      <= OP_STARTUP;
        rst_req_q <= 1'b1;
        rst_src_q <= SRC_FLASH;
      end else if (wr_ok) begin
        op_q <= next_op(op_q, fields.mcode, flash_ok);
      end
    end
  end
endmodule

// File: rtl/sbc_mode_ctrl.sv
module sbc_mode_ctrl
  import sbc_mode_pkg::*;
#(
  parameter int INIT_WIN_MS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cmd_word,
  input  logic        cmd_wr,
  input  logic        wd_ok,
  input  logic        tick_1ms,
  output logic [2:0]  op_mode,
  output logic        en_out,
  output logic        sw_dev,
  output logic        rd_diag,
  output logic        sys_rst_req,
  output logic [3:0]  rst_src
);
  cmd_fields_t fields;
  logic        wr_ok;
  logic        seq_fire;
  logic        win_open;
  op_state_e   op_q;

  sbc_cmd_decode #(.WORD_W(16)) u_dec (
    .cmd_word (cmd_word),
    .cmd_wr   (cmd_wr),
    .fields   (fields),
    .wr_ok    (wr_ok)
  );

  sbc_flash_seq #(.INIT_WIN_MS(INIT_WIN_MS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_hit  (fields.hit),
    .wr_ok    (wr_ok),
    .mcode    (fields.mcode),
    .wd_ok    (wd_ok),
    .tick_1ms (tick_1ms),
    .seq_fire (seq_fire),
    .win_open (win_open)
  );

  sbc_mode_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .fields    (fields),
    .wr_ok     (wr_ok),
    .seq_fire  (seq_fire),
    .win_open  (win_open),
    .op_q      (op_q),
    .en_q      (en_out),
    .sw_dev_q  (sw_dev),
    .rd_diag_q (rd_diag),
    .rst_req_q (sys_rst_req),
    .rst_src_q (rst_src)
  );

  assign op_mode = op_q;
endmodule

// File: rtl/sbc_mode_ctrl_chk.sv
module sbc_mode_ctrl_chk
  import sbc_mode_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cmd_word,
  input logic        cmd_wr,
  input logic [2:0]  op_mode,
  input logic        en_out,
  input logic        sw_dev,
  input logic        rd_diag,
  input logic        sys_rst_req,
  input logic [3:0]  rst_src,
  input logic        seq_fire,
  input logic        win_open
);
  logic mr_hit;
  assign mr_hit = cmd_wr && (cmd_word[15:14] == 2'b00);

  a_r1_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_word[15:14] != 2'b00) |=>
      ($stable(op_mode) && $stable(rd_diag) && $stable(en_out) && $stable(sw_dev)));

  a_r3_ro_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_hit && cmd_word[12]) |=>
      ($stable(op_mode) && $stable(en_out) && $stable(sw_dev)));

  a_r6_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_hit && !cmd_word[12] && cmd_word[5:3] == MC_NONE) |=>
      ($stable(op_mode) && $stable(en_out) && $stable(sw_dev)));

  a_r7_fire_to_req: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fire |=> sys_rst_req);

  a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);

  a_r7_req_state: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (op_mode == OP_STARTUP && rst_src == SRC_FLASH));

  a_r9_flash_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == OP_FLASH && $past(op_mode) != OP_FLASH) |->
      ($past(op_mode) == OP_STARTUP && $past(win_open)));

  a_r9_window_src: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> (rst_src == SRC_FLASH));
endmodule

bind sbc_mode_ctrl sbc_mode_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_word    (cmd_word),
  .cmd_wr      (cmd_wr),
  .op_mode     (op_mode),
  .en_out      (en_out),
  .sw_dev      (sw_dev),
  .rd_diag     (rd_diag),
  .sys_rst_req (sys_rst_req),
  .rst_src     (rst_src),
  .seq_fire    (seq_fire),
  .win_open    (win_open)
);

// File: tb/sbc_mode_ctrl_tb.sv
module sbc_mode_ctrl_tb;
  localparam int WIN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        cmd_wr = 1'b0;
  logic        wd_ok = 1'b0;
  logic        tick_1ms = 1'b0;
  logic [2:0]  op_mode;
  logic        en_out, sw_dev, rd_diag, sys_rst_req;
  logic [3:0]  rst_src;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sbc_mode_ctrl #(.INIT_WIN_MS(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_wr(cmd_wr),
    .wd_ok(wd_ok), .tick_1ms(tick_1ms), .op_mode(op_mode), .en_out(en_out),
    .sw_dev(sw_dev), .rd_diag(rd_diag), .sys_rst_req(sys_rst_req), .rst_src(rst_src)
  );

  typedef struct {
    int    op;
    bit    en, sw, rd, rq;
    int    src;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  // Reference model state
  int m_op = 0, m_src = 1, m_step = 0, m_cnt = 0;
  bit m_en = 0, m_sw = 0, m_rd = 0, m_win = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per write, sampled on the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, "op_mode", int'(op_mode), e.op);
      check(e.tag, "en_out", int'(en_out), int'(e.en));
      check(e.tag, "sw_dev", int'(sw_dev), int'(e.sw));
      check(e.tag, "rd_diag", int'(rd_diag), int'(e.rd));
      check(e.tag, "sys_rst_req", int'(sys_rst_req), int'(e.rq));
      check(e.tag, "rst_src", int'(rst_src), e.src);
    end
  end

  // Driver: one write, the model computes the expected outcome
  task automatic wr(input string tag, input bit [1:0] a, input bit rd, input bit ro,
                    input bit [2:0] code, input bit sw, input bit en, input bit wdk);
    exp_t e;
    bit rq;
    bit fire;
    int want;
    rq = 0;
    if (a == 2'b00) begin
      m_rd = rd;
      if (ro || code == 3'd0) begin
        m_step = 0;
      end else begin
        m_en = en;
        m_sw = sw;
        want = (m_step % 2 == 1) ? 7 : 1;
        fire = wdk && (int'(code) == want) && (m_step == 3);
        if (wdk && int'(code) == want) m_step = (m_step + 1) % 4;
        else m_step = 0;
        if (fire) begin
          m_op = 0; m_src = 10; rq = 1; m_win = 1; m_cnt = 0;
        end else if (m_op == 4) begin
          if (code == 3'd6) m_op = 0;
        end else begin
          case (code)
            3'd1, 3'd5: m_op = 1;
            3'd2:       m_op = 2;
            3'd4:       m_op = 3;
            3'd3:       if (m_op == 0 && m_win && m_src == 10) m_op = 4;
            default:    ;
          endcase
        end
      end
    end
    @(negedge clk);
    cmd_word = {a, rd, ro, 6'b0, code, sw, en, 1'b0};
    cmd_wr = 1'b1;
    wd_ok = wdk;
    @(posedge clk);
    #1;
    e.op = m_op; e.en = m_en; e.sw = m_sw; e.rd = m_rd; e.rq = rq; e.src = m_src; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    cmd_wr = 1'b0;
    wd_ok = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_1ms = 1'b1;
      if (m_win) begin
        if (m_cnt == WIN - 1) m_win = 0;
        else m_cnt++;
      end
      @(negedge clk);
      tick_1ms = 1'b0;
    end
  endtask

  task automatic full_seq(input string tag);
    wr(tag, 2'b00, 0, 0, 3'd1, 0, 1, 1);
    wr(tag, 2'b00, 0, 0, 3'd7, 0, 1, 1);
    wr(tag, 2'b00, 0, 0, 3'd1, 0, 1, 1);
    wr(tag, 2'b00, 0, 0, 3'd7, 0, 1, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset values
    check("R11", "op_mode", int'(op_mode), 0);
    check("R11", "en_out", int'(en_out), 0);
    check("R11", "sw_dev", int'(sw_dev), 0);
    check("R11", "rd_diag", int'(rd_diag), 0);
    check("R11", "sys_rst_req", int'(sys_rst_req), 0);
    check("R11", "rst_src", int'(rst_src), 1);
    rst_n = 1'b1;
    @(negedge clk);

    wr("R4_R5_R2", 2'b00, 1, 0, 3'd2, 0, 1, 1);  // Standby, en, diag select
    wr("R4_R5",    2'b00, 1, 0, 3'd4, 1, 0, 1);  // Sleep, sw_dev
    wr("R4",       2'b00, 0, 0, 3'd5, 0, 1, 0);  // initialize Normal
    wr("R1",       2'b01, 1, 0, 3'd2, 1, 0, 1);  // other register: no effect
    wr("R1",       2'b11, 1, 0, 3'd4, 1, 0, 1);
    wr("R3_R2",    2'b00, 1, 1, 3'd2, 1, 0, 1);  // read-only: only rd_diag
    wr("R6",       2'b00, 0, 0, 3'd0, 1, 0, 1);  // code 000 ignored
    wr("R9",       2'b00, 0, 0, 3'd3, 0, 1, 1);  // init Flash without sequence
    wr("R10",      2'b00, 0, 0, 3'd7, 0, 1, 1);  // direct Flash code

    // R8 broken order
    wr("R8", 2'b00, 0, 0, 3'd1, 0, 1, 1);
    wr("R8", 2'b00, 0, 0, 3'd7, 0, 1, 1);
    wr("R8", 2'b00, 0, 0, 3'd2, 0, 1, 1);
    wr("R8", 2'b00, 0, 0, 3'd7, 0, 1, 1);
    // R8 watchdog qualifier low on third step
    wr("R8", 2'b00, 0, 0, 3'd1, 0, 1, 1);
    wr("R8", 2'b00, 0, 0, 3'd7, 0, 1, 1);
    wr("R8", 2'b00, 0, 0, 3'd1, 0, 1, 0);
    wr("R8", 2'b00, 0, 0, 3'd7, 0, 1, 1);
    // R8 read-only access in the middle
    wr("R8", 2'b00, 0, 0, 3'd1, 0, 1, 1);
    wr("R8", 2'b00, 0, 0, 3'd7, 0, 1, 1);
    wr("R8", 2'b00, 0, 0, 3'd1, 0, 1, 1);
    wr("R8", 2'b00, 0, 1, 3'd1, 0, 1, 1);
    wr("R8", 2'b00, 0, 0, 3'd7, 0, 1, 1);

    full_seq("R7");                                // forced reset
    ticks(WIN);
    wr("R9", 2'b00, 0, 0, 3'd3, 0, 1, 1);          // window expired
    full_seq("R7");
    ticks(WIN - 1);
    wr("R9", 2'b00, 0, 0, 3'd3, 0, 1, 1);          // inside window: Flash
    wr("R10", 2'b00, 0, 0, 3'd1, 0, 1, 1);         // Normal ignored in Flash
    wr("R10", 2'b00, 0, 0, 3'd2, 1, 0, 1);         // Standby ignored in Flash
    wr("R10", 2'b00, 0, 0, 3'd6, 0, 1, 1);         // leave Flash

    repeat (3) @(negedge clk);
    check("R7", "queue drained", sb_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule